// File: doc/BRIEF.md
# Mute Ramp and Interrupt Flag Controller

This block sequences the soft-mute behaviour of an audio converter's digital playback path and its headphone stage. Two ramp engines, one for the DAC digital attenuation and one for the headphone output, each walk an attenuation code between 0 (0 dB) and 31 (-31 dB, muted). They move one code per step of a free-running tick whenever their mute control changes. When a ramp lands on its target, a sticky completion flag for that direction is raised.

The flags live in a 7-bit register that software clears by writing ones. A mask register of the same layout gates the flags into a single registered interrupt line. A 2-bit form field in a control register selects the line's polarity. While a stage is in standby, its attenuation follows the mute control at once and raises no flag.

Top module: `mute_ramp_ctrl`

## Requirements
- R1: Out of reset both attenuation codes read 31, the flag register reads 0, the mask register reads 7'h7F, and the interrupt output is low.
- R2: Flag bit 1 marks a completed DAC unmute ramp, bit 0 a completed DAC mute ramp, bit 3 a completed headphone unmute ramp and bit 2 a completed headphone mute ramp. Bits 6 to 4 have no source here and read 0. Flags stay set until cleared. A flag write clears each bit whose data bit (wr_data_i[6:0]) is 1 and leaves bits written with 0 unchanged. A completion in the same cycle wins over the clear.
- R3: With the DAC out of standby, raising dac_mute_i steps the DAC code up to 31 and sets flag bit 0 on the edge where 31 is reached. Lowering it steps the code down to 0 and sets flag bit 1 on the edge where 0 is reached.
- R4: An attenuation code changes by at most one per tick. A tick occurs once every TICK_DIV clocks (default 16), counted from reset, and the code holds between ticks.
- R5: While dac_stby_i is high, the DAC code takes its mute target on the next edge and neither DAC flag is set.
- R6: The headphone engine follows R3 and R5 with hp_mute_i, hp_stby_i and flag bits 3 (unmute done) and 2 (mute done).
- R7: A mute change during a ramp continues from the current code toward the new target. Only the flag for the final direction is raised.
- R8: When the form field is 00, irq_o is high one cycle after any flag bit is set with its mask bit 0, and low one cycle after no such bit remains.
- R9: The form field is wr_data_i[7:6], loaded on a control write. Any nonzero value inverts irq_o, which makes it active low.
- R10: A mask write loads wr_data_i[6:0] into the mask register, which mask_o reads back. A mask bit of 1 keeps that flag from the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dac_mute_i | input | 1 | DAC digital mute control |
| dac_stby_i | input | 1 | DAC standby control |
| hp_mute_i | input | 1 | Headphone mute control |
| hp_stby_i | input | 1 | Headphone standby control |
| wr_data_i | input | 8 | Write data shared by the three register strobes |
| flag_wr_i | input | 1 | Flag register write strobe (write-one-to-clear) |
| mask_wr_i | input | 1 | Mask register write strobe |
| ctrl_wr_i | input | 1 | Control register write strobe (form field) |
| flag_o | output | 7 | Flag register readback |
| mask_o | output | 7 | Mask register readback |
| dac_gain_o | output | GAIN_W | DAC attenuation code, 0 = 0 dB |
| hp_gain_o | output | GAIN_W | Headphone attenuation code, 0 = 0 dB |
| irq_o | output | 1 | Registered interrupt line |

## Verification
A wrong tick phase or step direction shows on the attenuation outputs at the next tick, within TICK_DIV cycles. A lost or misrouted completion shows in flag_o on the exact edge where a code reaches 0 or 31. Mask and polarity faults show on irq_o one cycle after the register write. A reference model runs alongside the design from reset and is compared against every output after each random burst, so a divergence is caught at the end of the burst in which it occurs.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
   localparam int FLAG_W    = 7;
   localparam int WDATA_W   = 8;
   localparam int N_ENGINES = 2;
   // engine index: 0 = DAC, 1 = headphone; flag bit = 2*idx + (unmute ? 1 : 0)
   localparam int ENG_DAC   = 0;
   localparam int ENG_HP    = 1;
   localparam int FORM_LSB  = 6;
   localparam logic [1:0] FORM_ACT_HIGH = 2'b00;
endpackage

// File: rtl/mrc_tick_gen.sv
module mrc_tick_gen #(
   parameter int TICK_DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int CNT_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

   if (TICK_DIV < 2) begin : g_bad_div
      $error("TICK_DIV must be at least 2");
   end

   logic [CNT_W-1:0] cnt_q;

   assign tick_o = (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + CNT_W'(1);
   end

   // R4: ticks never come back to back
   p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);
endmodule

// File: rtl/mrc_ramp_unit.sv
module mrc_ramp_unit #(
   parameter int GAIN_W   = 5,
   parameter int GAIN_MAX = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              mute_i,
   input  logic              stby_i,
   output logic [GAIN_W-1:0] gain_o,
   output logic              done_up_o,
   output logic              done_dn_o
);
   localparam logic [GAIN_W-1:0] CODE_MUTED = GAIN_MAX[GAIN_W-1:0];

   if (GAIN_MAX >= (1 << GAIN_W) || GAIN_MAX < 1) begin : g_bad_gain
      $error("GAIN_MAX must fit in GAIN_W bits");
   end

   logic [GAIN_W-1:0] gain_q, gain_d, target;

   assign target = mute_i ? CODE_MUTED : '0;

   always_comb begin
      gain_d    = gain_q;
      done_up_o = 1'b0;
      done_dn_o = 1'b0;
      if (stby_i) begin
         gain_d = target;
      end else if (tick_i && (gain_q != target)) begin
         if (gain_q < target) gain_d = gain_q + GAIN_W'(1);
         else                 gain_d = gain_q - GAIN_W'(1);
         if (gain_d == target) begin
            done_dn_o = mute_i;
            done_up_o = !mute_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gain_q <= CODE_MUTED;
      else        gain_q <= gain_d;
   end

   assign gain_o = gain_q;

   // R4: outside standby the code moves at most one step per edge
   p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stby_i) |-> (gain_q == $past(gain_q)) ||
                         (gain_q == $past(gain_q) + GAIN_W'(1)) ||
                         (gain_q == $past(gain_q) - GAIN_W'(1)));
   // R4: no movement between ticks
   p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!stby_i && !tick_i) |=> $stable(gain_q));
   // R3: mute completion lands on the muted code
   p_done_dn_at_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_dn_o |=> (gain_q == CODE_MUTED));
   // R3: unmute completion lands on code 0
   p_done_up_at_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_up_o |=> (gain_q == '0));
endmodule

// File: rtl/mrc_flag_irq.sv
module mrc_flag_irq
   import mrc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FLAG_W-1:0]  set_i,
   input  logic [WDATA_W-1:0] wdata_i,
   input  logic               flag_wr_i,
   input  logic               mask_wr_i,
   input  logic               ctrl_wr_i,
   output logic [FLAG_W-1:0]  flag_o,
   output logic [FLAG_W-1:0]  mask_o,
   output logic               irq_o
);
   logic [FLAG_W-1:0] flag_q, mask_q, clr;
   logic [1:0]        form_q;
   logic              pend, irq_q;

   assign clr  = flag_wr_i ? wdata_i[FLAG_W-1:0] : '0;
   assign pend = |(flag_q & ~mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
         mask_q <= '1;
         form_q <= FORM_ACT_HIGH;
         irq_q  <= 1'b0;
      end else begin
         flag_q <= (flag_q & ~clr) | set_i;
         if (mask_wr_i) mask_q <= wdata_i[FLAG_W-1:0];
         if (ctrl_wr_i) form_q <= wdata_i[FORM_LSB +: 2];
         irq_q  <= (form_q == FORM_ACT_HIGH) ? pend : !pend;
      end
   end

   assign flag_o = flag_q;
   assign mask_o = mask_q;
   assign irq_o  = irq_q;

   // R2: a flag only drops through a write
   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_wr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
   // R2: written ones clear when nothing completes in that cycle
   p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr_i && (set_i == '0)) |=> ((flag_q & $past(wdata_i[FLAG_W-1:0])) == '0));
   // R8: active-high form, no unmasked flag, line low next cycle
   p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((form_q == FORM_ACT_HIGH) && ((flag_o & ~mask_o) == '0)) |=> !irq_o);
   // R9: inverted form with an unmasked flag drives the line low
   p_irq_inverted_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((form_q != FORM_ACT_HIGH) && ((flag_o & ~mask_o) != '0)) |=> !irq_o);
endmodule

// File: rtl/mute_ramp_ctrl.sv
module mute_ramp_ctrl
   import mrc_pkg::*;
#(
   parameter int GAIN_W   = 5,
   parameter int GAIN_MAX = 31,
   parameter int TICK_DIV = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dac_mute_i,
   input  logic               dac_stby_i,
   input  logic               hp_mute_i,
   input  logic               hp_stby_i,
   input  logic [WDATA_W-1:0] wr_data_i,
   input  logic               flag_wr_i,
   input  logic               mask_wr_i,
   input  logic               ctrl_wr_i,
   output logic [FLAG_W-1:0]  flag_o,
   output logic [FLAG_W-1:0]  mask_o,
   output logic [GAIN_W-1:0]  dac_gain_o,
   output logic [GAIN_W-1:0]  hp_gain_o,
   output logic               irq_o
);
   localparam int USED_FLAGS = 2 * N_ENGINES;

   if (USED_FLAGS > FLAG_W) begin : g_bad_flags
      $error("not enough flag bits for the ramp engines");
   end

   logic                       tick;
   logic [N_ENGINES-1:0]       mute_v, stby_v, up_v, dn_v;
   logic [GAIN_W-1:0]          gain_v [N_ENGINES];
   logic [FLAG_W-1:0]          set_v;

   assign mute_v[ENG_DAC] = dac_mute_i;
   assign mute_v[ENG_HP]  = hp_mute_i;
   assign stby_v[ENG_DAC] = dac_stby_i;
   assign stby_v[ENG_HP]  = hp_stby_i;

   mrc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   for (genvar e = 0; e < N_ENGINES; e++) begin : g_eng
      mrc_ramp_unit #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX)) u_ramp (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick_i    (tick),
         .mute_i    (mute_v[e]),
         .stby_i    (stby_v[e]),
         .gain_o    (gain_v[e]),
         .done_up_o (up_v[e]),
         .done_dn_o (dn_v[e])
      );
      assign set_v[2*e]   = dn_v[e];
      assign set_v[2*e+1] = up_v[e];
   end

   for (genvar b = USED_FLAGS; b < FLAG_W; b++) begin : g_nosrc
      assign set_v[b] = 1'b0;
   end

   mrc_flag_irq u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_v),
      .wdata_i   (wr_data_i),
      .flag_wr_i (flag_wr_i),
      .mask_wr_i (mask_wr_i),
      .ctrl_wr_i (ctrl_wr_i),
      .flag_o    (flag_o),
      .mask_o    (mask_o),
      .irq_o     (irq_o)
   );

   assign dac_gain_o = gain_v[ENG_DAC];
   assign hp_gain_o  = gain_v[ENG_HP];

   // R5: a DAC in standby never raises a DAC completion flag
   p_stby_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_stby_i && !flag_wr_i && (flag_o[1:0] == 2'b00)) |=> (flag_o[1:0] == 2'b00));
   // R6: a headphone stage in standby never raises its flags
   p_hp_stby_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (hp_stby_i && !flag_wr_i && (flag_o[3:2] == 2'b00)) |=> (flag_o[3:2] == 2'b00));
endmodule

// File: tb/test_mute_ramp_ctrl.sv
module test_mute_ramp_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int TICK       = 16;
   localparam int GMAX       = 31;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dac_mute = 1'b1, dac_stby = 1'b0, hp_mute = 1'b1, hp_stby = 1'b0;
   logic [7:0] wr_data = '0;
   logic       flag_wr = 1'b0, mask_wr = 1'b0, ctrl_wr = 1'b0;
   logic [6:0] flag_o, mask_o;
   logic [4:0] dac_gain, hp_gain;
   logic       irq;

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   mute_ramp_ctrl #(.GAIN_W(5), .GAIN_MAX(GMAX), .TICK_DIV(TICK)) i_mute_ramp_ctrl (
      .clk(clk), .rst_n(rst_n),
      .dac_mute_i(dac_mute), .dac_stby_i(dac_stby),
      .hp_mute_i(hp_mute), .hp_stby_i(hp_stby),
      .wr_data_i(wr_data), .flag_wr_i(flag_wr), .mask_wr_i(mask_wr), .ctrl_wr_i(ctrl_wr),
      .flag_o(flag_o), .mask_o(mask_o), .dac_gain_o(dac_gain), .hp_gain_o(hp_gain),
      .irq_o(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // reference model built from the requirements
   int         m_cnt;
   int         m_g [2];
   logic [6:0] m_flag, m_mask, m_set;
   logic [1:0] m_form;
   logic       m_irq, m_tick, m_mute, m_stby, m_pend;
   int         m_tgt, m_nx;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cnt <= 0; m_g[0] <= GMAX; m_g[1] <= GMAX;
         m_flag <= '0; m_mask <= 7'h7F; m_form <= 2'b00; m_irq <= 1'b0;
      end else begin
         m_tick = (m_cnt == TICK - 1);
         m_set  = '0;
         m_cnt <= m_tick ? 0 : m_cnt + 1;
         for (int u = 0; u < 2; u++) begin
            m_mute = (u == 0) ? dac_mute : hp_mute;
            m_stby = (u == 0) ? dac_stby : hp_stby;
            m_tgt  = m_mute ? GMAX : 0;
            if (m_stby) m_g[u] <= m_tgt;
            else if (m_tick && m_g[u] != m_tgt) begin
               m_nx = (m_g[u] < m_tgt) ? m_g[u] + 1 : m_g[u] - 1;
               m_g[u] <= m_nx;
               if (m_nx == m_tgt) m_set[2*u + (m_mute ? 0 : 1)] = 1'b1;
            end
         end
         m_pend = |(m_flag & ~m_mask);
         m_flag <= (m_flag & ~(flag_wr ? wr_data[6:0] : 7'h00)) | m_set;
         if (mask_wr) m_mask <= wr_data[6:0];
         if (ctrl_wr) m_form <= wr_data[7:6];
         m_irq <= (m_form == 2'b00) ? m_pend : !m_pend;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cmp_model();
      chk("R3 dac code vs model", 32'(dac_gain), 32'(m_g[0]));
      chk("R6 hp code vs model", 32'(hp_gain), 32'(m_g[1]));
      chk("R2 flags vs model", 32'(flag_o), 32'(m_flag));
      chk("R10 mask vs model", 32'(mask_o), 32'(m_mask));
      chk("R8 irq vs model", 32'(irq), 32'(m_irq));
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int which, input logic [7:0] d);
      @(negedge clk);
      wr_data = d;
      flag_wr = (which == 0); mask_wr = (which == 1); ctrl_wr = (which == 2);
      @(negedge clk);
      flag_wr = 1'b0; mask_wr = 1'b0; ctrl_wr = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int seed;
      int g;
      seed = $urandom(32'd20240611);
      cyc(3);
      // R1: reset values
      chk("R1 dac code in reset", 32'(dac_gain), 31);
      chk("R1 hp code in reset", 32'(hp_gain), 31);
      chk("R1 flags in reset", 32'(flag_o), 0);
      chk("R1 mask in reset", 32'(mask_o), 32'h7F);
      chk("R1 irq in reset", 32'(irq), 0);
      rst_n = 1'b1;
      cyc(2);
      chk("R1 dac code after reset", 32'(dac_gain), 31);

      // R3 / R4: unmute ramp, midpoint and end
      dac_mute = 1'b0;
      cyc(8 * TICK);
      g = int'(dac_gain);
      chk("R4 dac code after 8 ticks in 22..24", 32'((g >= 22) && (g <= 24)), 1);
      cyc(32 * TICK);
      chk("R3 dac code reaches 0", 32'(dac_gain), 0);
      chk("R3 unmute sets bit1 only", 32'(flag_o), 32'h02);
      chk("R10 masked flag keeps irq low", 32'(irq), 0);
      cmp_model();

      // R8 / R10: unmask bit1
      wr(1, 8'h7D);
      cyc(1);
      chk("R10 mask readback", 32'(mask_o), 32'h7D);
      chk("R8 irq high with unmasked flag", 32'(irq), 1);
      // R2: clear bit1
      wr(0, 8'h02);
      cyc(1);
      chk("R2 write one clears", 32'(flag_o), 0);
      chk("R8 irq drops after clear", 32'(irq), 0);

      // R3: mute ramp, R9 polarity
      dac_mute = 1'b1;
      cyc(33 * TICK);
      chk("R3 dac code reaches 31", 32'(dac_gain), 31);
      chk("R3 mute sets bit0 only", 32'(flag_o), 32'h01);
      wr(1, 8'h7E);
      cyc(1);
      chk("R8 irq high for bit0", 32'(irq), 1);
      wr(2, 8'h40);
      cyc(1);
      chk("R9 nonzero form inverts pending irq", 32'(irq), 0);
      wr(0, 8'h7F);
      cyc(1);
      chk("R9 nonzero form idles high", 32'(irq), 1);
      wr(2, 8'h00);
      cyc(1);
      chk("R9 form 00 idles low", 32'(irq), 0);

      // R5: standby jumps, no flags
      dac_stby = 1'b1;
      dac_mute = 1'b0;
      cyc(2);
      chk("R5 standby unmute jumps to 0", 32'(dac_gain), 0);
      chk("R5 standby raises no flag", 32'(flag_o), 0);
      dac_mute = 1'b1;
      cyc(2);
      chk("R5 standby mute jumps to 31", 32'(dac_gain), 31);
      chk("R5 standby raises no flag on mute", 32'(flag_o), 0);
      dac_stby = 1'b0;

      // R7: reversal mid ramp
      dac_mute = 1'b0;
      cyc(5 * TICK);
      g = int'(dac_gain);
      chk("R7 ramp partway", 32'((g > 20) && (g < 31)), 1);
      dac_mute = 1'b1;
      cyc(40 * TICK);
      chk("R7 back at 31", 32'(dac_gain), 31);
      chk("R7 only final direction flag", 32'(flag_o), 32'h01);
      wr(0, 8'h7F);

      // R6: headphone ramps
      hp_mute = 1'b0;
      cyc(33 * TICK);
      chk("R6 hp code reaches 0", 32'(hp_gain), 0);
      chk("R6 hp unmute sets bit3", 32'(flag_o), 32'h08);
      hp_mute = 1'b1;
      cyc(33 * TICK);
      chk("R6 hp code reaches 31", 32'(hp_gain), 31);
      chk("R6 hp mute sets bit2", 32'(flag_o), 32'h0C);
      wr(0, 8'h04);
      cyc(1);
      chk("R2 zero bits leave flags unchanged", 32'(flag_o), 32'h08);
      cmp_model();

      // random phase against the model
      for (int it = 0; it < 250; it++) begin
         @(negedge clk);
         case ($urandom_range(0, 7))
            0: dac_mute = !dac_mute;
            1: hp_mute  = !hp_mute;
            2: dac_stby = ($urandom_range(0, 3) == 0);
            3: hp_stby  = ($urandom_range(0, 3) == 0);
            4: wr(0, 8'($urandom));
            5: wr(1, 8'($urandom));
            6: wr(2, 8'($urandom));
            default: ;
         endcase
         cyc($urandom_range(1, 80));
         cmp_model();
      end
      chk("R2 unsourced bits read 0", 32'(flag_o[6:4]), 0);
      finish_run();
   end
endmodule